// File: doc/BRIEF.md
# Serial Configuration and Correction-Memory Loader

This block takes a write-only three-wire serial stream (active-low select, serial clock, serial data) and turns it into write strobes for three correction-point memories and into a bank of decoded timing and mode registers. The three serial wires are resynchronised into the system clock domain. Serial clock rising edges are found by comparing successive synchronised samples, so all state advances on the system clock.

Each frame opens with a target-mask byte and then a start-address byte. Any number of payload bytes follow. The mask can name several targets at once, so one frame can load the same payload into all three memories and the register bank together. The write pointer starts at the address byte and steps once per payload byte. A busy flag covers the whole transfer so that downstream output logic can show its fixed idle level while the tables are changing.

Top module: `serial_cfg_loader`

## Requirements
- R1: Serial bits are taken MSB first on each synchronised serial-clock rise while select is low. Byte 1 of a frame is the target mask, byte 2 is the start address, and every later byte is payload.
- R2: Mask bit 0, bit 1 and bit 2 enable memory 0, memory 1 and memory 2, seen as `memWe` bits 0, 1 and 2. Mask bit 3 enables the register bank. Any combination of these bits is written in parallel.
- R3: The first payload byte is written at the start address. Each further payload byte in the same frame goes to the next address.
- R4: A memory write carries only payload bits 5..0 on `memData`. Payload bits 7 and 6 are discarded.
- R5: A payload byte whose address is 208 or higher produces no memory strobe. The pointer stops at 256 and never wraps back to low addresses.
- R6: Register bank byte positions are fixed as follows:
  - 0: `hFirst`[7:4], `hLast`[3:0]
  - 1: `vFirst`[7:4], `vLast`[3:0]
  - 2: `hStartPos`
  - 3: `hPitch`
  - 4: `vStartPos`[3:0]
  - 5: `vStep`[4:0]
  - 6: `vPitch`[5:0]
  - 7: `vPitchInv`[6:0]
  - 8: `corrEnable`[7], `hsyncPolPos`[6], `vstPolPos`[5], `vScanNormal`[4], `hScanNormal`[3], `dacPhase`[2:0]
  - 9: `standby`[7:6], `idleLevel`[5:0]

  Register addresses 10 and above are ignored. Register fields change only while `busy` is high.
- R7: Raising select ends the frame and discards any partly received byte. The next frame starts again with a mask byte.
- R8: `busy` is high while the synchronised select is low and while the last received byte is still being written. It is low otherwise, and every memory strobe occurs while it is high.
- R9: After the active-low reset, all register fields are zero, `busy` is low and no strobe is active.
- R10: Every accepted payload byte raises the enabled `memWe` bits for exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| serSelN | input | 1 | Serial select, active low |
| serClk | input | 1 | Serial clock |
| serData | input | 1 | Serial data |
| memWe | output | 3 | Write strobe per correction memory |
| memAddr | output | 8 | Memory write address |
| memData | output | 6 | Memory write data |
| hFirst | output | 4 | First horizontal point used |
| hLast | output | 4 | Last horizontal point used |
| vFirst | output | 4 | First vertical point used |
| vLast | output | 4 | Last vertical point used |
| hStartPos | output | 8 | Horizontal output start offset |
| hPitch | output | 8 | Horizontal point spacing minus one |
| vStartPos | output | 4 | Vertical start line |
| vStep | output | 5 | Vertical processing interval |
| vPitch | output | 6 | Vertical point spacing in lines |
| vPitchInv | output | 7 | Reciprocal of vertical spacing |
| corrEnable | output | 1 | Correction on when high |
| hsyncPolPos | output | 1 | Horizontal sync polarity is positive |
| vstPolPos | output | 1 | Vertical start polarity is positive |
| vScanNormal | output | 1 | Normal vertical read order |
| hScanNormal | output | 1 | Normal horizontal read order |
| dacPhase | output | 3 | Converter clock phase |
| standby | output | 2 | Standby code |
| idleLevel | output | 6 | Level shown when correction is off or busy |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest situations to reach are the ones where nothing visible should happen. These are a byte cut short by select rising, payload at addresses at or beyond the memory end, and payload aimed past the last register. The bench reaches them with frames that stop after five bits, frames that start at address 206 or 255, and a register frame starting at address 10. In every such case the scoreboard holds no expected item, so any stray strobe shows up as unexpected. Register fields are read back through the ports after each such frame.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    BYTE_MAIN = 2'd0,
    BYTE_SUB  = 2'd1,
    BYTE_DATA = 2'd2
  } byteKind_t;

  typedef struct packed {
    logic                 valid;
    byteKind_t            kind;
    logic [BYTE_BITS-1:0] value;
  } byteStrobe_t;
endpackage

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serSelN,
  input  logic        serClk,
  input  logic        serData,
  output byteStrobe_t strobe,
  output logic        busy
);
  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  logic [SYNC_STAGES-1:0] selSync, clkSync, datSync;
  logic                   clkPrev;
  logic [CNT_W-1:0]       bitCnt;
  logic [BYTE_BITS-1:0]   shiftReg;
  byteKind_t              byteIdx;
  logic                   selLow, sclkRise, datBit;
  logic [BYTE_BITS-1:0]   nextByte;

  // two-stage (parameterised) resynchronisers for the three serial wires
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSync <= '1;
      clkSync <= '0;
      datSync <= '0;
      clkPrev <= 1'b0;
    end else begin
      selSync <= {selSync[SYNC_STAGES-2:0], serSelN};
      clkSync <= {clkSync[SYNC_STAGES-2:0], serClk};
      datSync <= {datSync[SYNC_STAGES-2:0], serData};
      clkPrev <= clkSync[SYNC_STAGES-1];
    end
  end

  assign selLow   = ~selSync[SYNC_STAGES-1];
  assign sclkRise = clkSync[SYNC_STAGES-1] & ~clkPrev;
  assign datBit   = datSync[SYNC_STAGES-1];
  assign nextByte = {shiftReg[BYTE_BITS-2:0], datBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      byteIdx  <= BYTE_MAIN;
      strobe   <= '0;
      busy     <= 1'b0;
    end else begin
      strobe.valid <= 1'b0;
      busy         <= selLow | strobe.valid;
      if (!selLow) begin
        bitCnt  <= '0;
        byteIdx <= BYTE_MAIN;
      end else if (sclkRise) begin
        shiftReg <= nextByte;
        if (bitCnt == LAST_BIT) begin
          bitCnt       <= '0;
          strobe.valid <= 1'b1;
          strobe.kind  <= byteIdx;
          strobe.value <= nextByte;
          if (byteIdx != BYTE_DATA) byteIdx <= byteKind_t'(byteIdx + 2'd1);
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfgld_dp.sv
module cfgld_dp
  import cfgld_pkg::*;
#(
  parameter int NUM_MEM   = 3,
  parameter int MEM_DEPTH = 208,
  parameter int MEM_BITS  = 6,
  parameter int NUM_REG   = 10,
  parameter int ADDR_W    = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  byteStrobe_t                       strobe,
  output logic [NUM_MEM-1:0]                memWe,
  output logic [ADDR_W-1:0]                 memAddr,
  output logic [MEM_BITS-1:0]               memData,
  output logic [NUM_REG-1:0][BYTE_BITS-1:0] regBank
);
  localparam int PTR_W     = ADDR_W + 1;
  localparam int REG_IDX_W = $clog2(NUM_REG);

  logic [NUM_MEM:0]   mask;
  logic [PTR_W-1:0]   ptr;
  logic               memInRange, regInRange, isData;
  logic [NUM_MEM-1:0] memHit;

  assign isData     = strobe.valid && (strobe.kind == BYTE_DATA);
  assign memInRange = ptr < PTR_W'(MEM_DEPTH);
  assign regInRange = ptr < PTR_W'(NUM_REG);

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_hit
    assign memHit[g] = isData & mask[g] & memInRange;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask    <= '0;
      ptr     <= '0;
      memWe   <= '0;
      memAddr <= '0;
      memData <= '0;
      regBank <= '0;
    end else begin
      memWe <= memHit;
      if (strobe.valid) begin
        case (strobe.kind)
          BYTE_MAIN: mask <= strobe.value[NUM_MEM:0];
          BYTE_SUB:  ptr  <= {1'b0, strobe.value[ADDR_W-1:0]};
          default: begin
            memAddr <= ptr[ADDR_W-1:0];
            memData <= strobe.value[MEM_BITS-1:0];
            if (mask[NUM_MEM] && regInRange)
              regBank[ptr[REG_IDX_W-1:0]] <= strobe.value;
            if (!ptr[PTR_W-1]) ptr <= ptr + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int NUM_MEM     = 3,
  parameter int MEM_DEPTH   = 208,
  parameter int MEM_BITS    = 6,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serSelN,
  input  logic                serClk,
  input  logic                serData,
  output logic [NUM_MEM-1:0]  memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [MEM_BITS-1:0] memData,
  output logic [3:0]          hFirst,
  output logic [3:0]          hLast,
  output logic [3:0]          vFirst,
  output logic [3:0]          vLast,
  output logic [7:0]          hStartPos,
  output logic [7:0]          hPitch,
  output logic [3:0]          vStartPos,
  output logic [4:0]          vStep,
  output logic [5:0]          vPitch,
  output logic [6:0]          vPitchInv,
  output logic                corrEnable,
  output logic                hsyncPolPos,
  output logic                vstPolPos,
  output logic                vScanNormal,
  output logic                hScanNormal,
  output logic [2:0]          dacPhase,
  output logic [1:0]          standby,
  output logic [5:0]          idleLevel,
  output logic                busy
);
  localparam int NUM_REG = 10;

  byteStrobe_t                       strobe;
  logic [NUM_REG-1:0][BYTE_BITS-1:0] regBank;

  cfgld_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serSelN(serSelN), .serClk(serClk),
    .serData(serData), .strobe(strobe), .busy(busy)
  );

  cfgld_dp #(
    .NUM_MEM(NUM_MEM), .MEM_DEPTH(MEM_DEPTH), .MEM_BITS(MEM_BITS),
    .NUM_REG(NUM_REG), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .regBank(regBank)
  );

  assign {hFirst, hLast} = regBank[0];
  assign {vFirst, vLast} = regBank[1];
  assign hStartPos       = regBank[2];
  assign hPitch          = regBank[3];
  assign vStartPos       = regBank[4][3:0];
  assign vStep           = regBank[5][4:0];
  assign vPitch          = regBank[6][5:0];
  assign vPitchInv       = regBank[7][6:0];
  assign {corrEnable, hsyncPolPos, vstPolPos, vScanNormal, hScanNormal, dacPhase} = regBank[8];
  assign {standby, idleLevel} = regBank[9];
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int MEM_DEPTH = 208
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] memWe,
  input logic [7:0] memAddr,
  input logic       busy,
  input logic [7:0] hStartPos,
  input logic [5:0] idleLevel
);
  // R8
  mem_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe != 3'd0) |-> busy);

  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe != 3'd0) |=> (memWe == 3'd0));

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe != 3'd0) |-> (int'(memAddr) < MEM_DEPTH));

  // R6
  reg_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ($stable(hStartPos) && $stable(idleLevel)));
endmodule

bind serial_cfg_loader cfgld_chk #(.MEM_DEPTH(MEM_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr), .busy(busy),
  .hStartPos(hStartPos), .idleLevel(idleLevel)
);

// File: tb/tb_serial_cfg_loader.sv
module tb_serial_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0, rstN = 1'b0;
  logic serSelN = 1'b1, serClk = 1'b0, serData = 1'b0;
  logic [2:0] memWe;
  logic [7:0] memAddr;
  logic [5:0] memData;
  logic [3:0] hFirst, hLast, vFirst, vLast, vStartPos;
  logic [7:0] hStartPos, hPitch;
  logic [4:0] vStep;
  logic [5:0] vPitch, idleLevel;
  logic [6:0] vPitchInv;
  logic corrEnable, hsyncPolPos, vstPolPos, vScanNormal, hScanNormal, busy;
  logic [2:0] dacPhase;
  logic [1:0] standby;

  int compared = 0, mismatched = 0;
  logic [16:0] expQ[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_loader dut (
    .clk(clk), .rstN(rstN), .serSelN(serSelN), .serClk(serClk), .serData(serData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .hFirst(hFirst), .hLast(hLast), .vFirst(vFirst), .vLast(vLast),
    .hStartPos(hStartPos), .hPitch(hPitch), .vStartPos(vStartPos), .vStep(vStep),
    .vPitch(vPitch), .vPitchInv(vPitchInv), .corrEnable(corrEnable),
    .hsyncPolPos(hsyncPolPos), .vstPolPos(vstPolPos), .vScanNormal(vScanNormal),
    .hScanNormal(hScanNormal), .dacPhase(dacPhase), .standby(standby),
    .idleLevel(idleLevel), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe cycle pops one expected write
  always @(negedge clk) begin
    if (rstN && memWe != 3'd0) begin
      if (expQ.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R5/R7/R10 unexpected write actual=%0h expected=none",
                 {memWe, memAddr, memData});
      end else begin
        check("R1/R2/R3/R4 write", {15'd0, memWe, memAddr, memData}, {15'd0, expQ.pop_front()});
      end
    end
  end

  function automatic void expectWr(input logic [2:0] we, input logic [7:0] a, input logic [7:0] d);
    expQ.push_back({we, a, d[5:0]});
  endfunction

  task automatic sendBits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      serData = b[i];
      repeat (HALF) @(negedge clk);
      serClk = 1'b1;
      repeat (HALF) @(negedge clk);
      serClk = 1'b0;
    end
  endtask

  task automatic frameOpen();
    serSelN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frameClose();
    repeat (HALF) @(negedge clk);
    serSelN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9 busy", busy, 0);
    check("R9 memWe", memWe, 0);
    check("R9 hStartPos", hStartPos, 0);
    check("R9 idleLevel", idleLevel, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R3 R4: memory 0, start 5, three bytes
    frameOpen();
    sendBits(8'h01, 8);
    check("R8 busy in frame", busy, 1);
    sendBits(8'h05, 8);
    expectWr(3'b001, 8'd5, 8'hA5); sendBits(8'hA5, 8);
    expectWr(3'b001, 8'd6, 8'h3C); sendBits(8'h3C, 8);
    expectWr(3'b001, 8'd7, 8'hFF); sendBits(8'hFF, 8);
    frameClose();
    check("R8 busy idle", busy, 0);
    check("R3 queue drained", expQ.size(), 0);

    // R2 broadcast to all three memories
    frameOpen();
    sendBits(8'h07, 8); sendBits(8'h00, 8);
    expectWr(3'b111, 8'd0, 8'h12); sendBits(8'h12, 8);
    frameClose();
    check("R2 queue drained", expQ.size(), 0);

    // R5 end of memory: 206,207 written, 208,209 dropped
    frameOpen();
    sendBits(8'h02, 8); sendBits(8'hCE, 8);
    expectWr(3'b010, 8'd206, 8'h01); sendBits(8'h01, 8);
    expectWr(3'b010, 8'd207, 8'h02); sendBits(8'h02, 8);
    sendBits(8'h03, 8); sendBits(8'h04, 8);
    frameClose();
    // R5 no wrap past 255
    frameOpen();
    sendBits(8'h04, 8); sendBits(8'hFF, 8);
    sendBits(8'h11, 8); sendBits(8'h22, 8); sendBits(8'h33, 8);
    frameClose();
    check("R5 queue drained", expQ.size(), 0);

    // R6 register bank load
    frameOpen();
    sendBits(8'h08, 8); sendBits(8'h00, 8);
    sendBits(8'h2D, 8); sendBits(8'h1C, 8); sendBits(8'h9A, 8); sendBits(8'h18, 8);
    sendBits(8'hF7, 8); sendBits(8'hE1, 8); sendBits(8'hF2, 8); sendBits(8'hA8, 8);
    sendBits(8'hB2, 8); sendBits(8'h95, 8);
    frameClose();
    check("R6 hFirst", hFirst, 4'h2);
    check("R6 hLast", hLast, 4'hD);
    check("R6 vFirst", vFirst, 4'h1);
    check("R6 vLast", vLast, 4'hC);
    check("R6 hStartPos", hStartPos, 8'h9A);
    check("R6 hPitch", hPitch, 8'h18);
    check("R6 vStartPos", vStartPos, 4'h7);
    check("R6 vStep", vStep, 5'h01);
    check("R6 vPitch", vPitch, 6'h32);
    check("R6 vPitchInv", vPitchInv, 7'h28);
    check("R6 mode", {corrEnable, hsyncPolPos, vstPolPos, vScanNormal, hScanNormal}, 5'b10110);
    check("R6 dacPhase", dacPhase, 3'd2);
    check("R6 standby", standby, 2'd2);
    check("R6 idleLevel", idleLevel, 6'h15);

    // R6 registers beyond 9 ignored
    frameOpen();
    sendBits(8'h08, 8); sendBits(8'h0A, 8); sendBits(8'h55, 8); sendBits(8'h66, 8);
    frameClose();
    check("R6 ignore hFirst", {hFirst, hLast}, 8'h2D);
    check("R6 ignore idleLevel", idleLevel, 6'h15);

    // R2 broadcast to memories and register bank together
    frameOpen();
    sendBits(8'h0F, 8); sendBits(8'h02, 8);
    expectWr(3'b111, 8'd2, 8'h77); sendBits(8'h77, 8);
    frameClose();
    check("R2 reg via broadcast", hStartPos, 8'h77);
    check("R2 queue drained", expQ.size(), 0);

    // R7 partial byte discarded, next frame restarts with mask
    frameOpen();
    sendBits(8'h01, 8); sendBits(8'h10, 8); sendBits(8'hFF, 5);
    frameClose();
    frameOpen();
    sendBits(8'h01, 8); sendBits(8'h20, 8);
    expectWr(3'b001, 8'h20, 8'h2A); sendBits(8'h2A, 8);
    frameClose();
    check("R7 queue drained", expQ.size(), 0);
    check("R7 busy idle", busy, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule